// File: doc/BRIEF.md
# PCI Express Configuration Window Decoder

This block holds the 64-bit base register that places the memory-mapped PCI Express configuration window. Configuration writes land on it through a byte-enabled write port. Every write whose enabled bytes touch the register triggers a fresh decode into three things: an enable, a window base and a window length. From that decode the block derives two more results. The first is a hit flag for a 32-bit request address. The second is the lower and upper bound of the 32-bit PCI memory hole, which sits above the configuration window and ends just under the interrupt-controller region.

A host-side address decoder uses the hit flag to decide whether a memory request belongs to the configuration window. Platform code reads the hole bounds to lay out device memory. The write port takes valid/ready. Ready is held high, so a write is taken in every cycle in which valid is high and no back-pressure ever reaches the source. The register sits at configuration dwords `REG_DW` (bits 31:0) and `REG_DW+1` (bits 63:32).

Top module: `mmcfg_window_top`

## Requirements
- R1: While `rst_n` is low and after it is released, the register holds 0xB000_0000. The decode is then: enable 0, base 0xB000_0000, length 256 MB (0x1000_0000), hole start 0xB000_0000, and `len_err` 0.
- R2: Register bit 0 is the enable. Bits 2:1 select the length: 00 is 256 MB, 01 is 128 MB, 10 is 64 MB and 11 is reserved. The new decode appears on the outputs in the cycle after the write is accepted.
- R3: With a 256 MB length, the base keeps register bits 35:28 only.
- R4: With a 128 MB length, the base keeps register bits 35:26.
- R5: With a 64 MB length, the base keeps register bits 35:28 and bit 26, and clears bit 27.
- R6: A register-touching write that leaves bits 2:1 at 11 raises `len_err` for exactly one cycle. The enable, base and length keep their previous values.
- R7: `cfg_hit` is high only when the enable is set and base ≤ `req_addr` < base + length. The comparison is zero-extended to the base width and is combinational in `req_addr`.
- R8: When the window is enabled, the hole starts at base + length. When it is disabled, the hole starts at 0xB000_0000.
- R9: The hole end is always 0xFEBF_FFFF, one byte below the interrupt-controller base 0xFEC0_0000.
- R10: A write to a dword other than `REG_DW` or `REG_DW+1` changes nothing, and so does a write with all byte enables clear. A partial write updates only the enabled byte lanes.
- R11: `cfg_wr_ready` is high whenever reset is released. A write is accepted when valid and ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_valid | input | 1 | Configuration write request |
| cfg_wr_ready | output | 1 | Write accepted when high together with valid |
| cfg_wr_dw | input | CFG_AW | Dword index in configuration space |
| cfg_wr_data | input | 32 | Write data |
| cfg_wr_be | input | 4 | Byte enables for the dword |
| req_addr | input | REQ_W | Request address to test against the window |
| cfg_hit | output | 1 | Request falls in the enabled window |
| win_en | output | 1 | Decoded enable |
| win_base | output | PA_W | Decoded window base |
| win_len | output | PA_W | Decoded window length in bytes |
| hole_start | output | PA_W | First byte of the PCI hole |
| hole_end | output | REQ_W | Last byte of the PCI hole |
| len_err | output | 1 | One-cycle pulse on a reserved-length write |

## Verification
The same high base bits are written under each of the three lengths. This shows whether bits 27 and 26 are masked per length, in particular whether the 64 MB case drops bit 27 while the 128 MB case keeps it. Request addresses one below, at, and one past each end of the window show off-by-one errors in the range compare. A reserved-length write is followed by a write to the upper dword alone, which shows whether a held decode stays held while the length field is still illegal. Writes to a foreign dword, with empty byte enables and to a single byte lane show whether stray traffic or whole-dword merging leaks into the register.

// File: rtl/mmcfg_pkg.sv
package mmcfg_pkg;
  localparam int PA_W   = 36;
  localparam int LG_MAX = 28;

  typedef enum logic [1:0] {
    LEN_256 = 2'b00,
    LEN_128 = 2'b01,
    LEN_64  = 2'b10,
    LEN_RSV = 2'b11
  } len_code_e;

  typedef struct packed {
    logic            en;
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] len;
  } win_dec_t;

  function automatic win_dec_t decode_raw(input logic [63:0] raw);
    win_dec_t        d;
    logic [PA_W-1:0] m;
    m = '0;
    m[PA_W-1:LG_MAX] = '1;
    d.en  = raw[0];
    d.len = '0;
    case (len_code_e'(raw[2:1]))
      LEN_128: begin
        m[LG_MAX-1] = 1'b1;
        m[LG_MAX-2] = 1'b1;
        d.len[LG_MAX-1] = 1'b1;
      end
      LEN_64: begin
        m[LG_MAX-2] = 1'b1;
        d.len[LG_MAX-2] = 1'b1;
      end
      default: d.len[LG_MAX] = 1'b1;
    endcase
    d.base = raw[PA_W-1:0] & m;
    return d;
  endfunction
endpackage

// File: rtl/mmcfg_cfg_port.sv
module mmcfg_cfg_port #(
  parameter int          CFG_AW  = 10,
  parameter int          REG_DW  = 24,
  parameter logic [63:0] RST_VAL = 64'h0000_0000_B000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [CFG_AW-1:0] wr_dw,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        wr_be,
  output logic [63:0]       raw_next,
  output logic              touch
);
  localparam int NBYTES = 8;
  logic [63:0]       raw_q;
  logic [NBYTES-1:0] lane_sel;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    localparam int DW = REG_DW + b / 4;
    localparam int LN = b % 4;
    assign lane_sel[b] = wr_fire && (wr_dw == CFG_AW'(DW)) && wr_be[LN];
    assign raw_next[8*b +: 8] = lane_sel[b] ? wr_data[8*LN +: 8] : raw_q[8*b +: 8];
  end

  assign touch = |lane_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= RST_VAL;
    else        raw_q <= raw_next;
  end
endmodule

// File: rtl/mmcfg_win_reg.sv
module mmcfg_win_reg
  import mmcfg_pkg::*;
#(
  parameter logic [63:0] RST_VAL = 64'h0000_0000_B000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        touch,
  input  logic [63:0] raw_next,
  output win_dec_t    dec,
  output logic        len_err
);
  logic rsvd;
  assign rsvd = (len_code_e'(raw_next[2:1]) == LEN_RSV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec     <= decode_raw(RST_VAL);
      len_err <= 1'b0;
    end else begin
      len_err <= touch && rsvd;
      if (touch && !rsvd) dec <= decode_raw(raw_next);
    end
  end
endmodule

// File: rtl/mmcfg_hit_cmp.sv
module mmcfg_hit_cmp
  import mmcfg_pkg::*;
#(
  parameter int          REQ_W      = 32,
  parameter logic [63:0] DEF_BASE   = 64'h0000_0000_B000_0000,
  parameter logic [63:0] IOAPIC_BASE = 64'h0000_0000_FEC0_0000
) (
  input  win_dec_t          dec,
  input  logic [REQ_W-1:0]  req_addr,
  output logic              hit,
  output logic [PA_W-1:0]   hole_start,
  output logic [REQ_W-1:0]  hole_end
);
  localparam logic [63:0] HOLE_TOP = IOAPIC_BASE - 64'd1;
  logic [PA_W:0] a_ext, lo, hi;

  assign a_ext = (PA_W+1)'(req_addr);
  assign lo    = {1'b0, dec.base};
  assign hi    = {1'b0, dec.base} + {1'b0, dec.len};

  assign hit        = dec.en && (a_ext >= lo) && (a_ext < hi);
  assign hole_start = dec.en ? hi[PA_W-1:0] : DEF_BASE[PA_W-1:0];
  assign hole_end   = HOLE_TOP[REQ_W-1:0];
endmodule

// File: rtl/mmcfg_window_top.sv
module mmcfg_window_top
  import mmcfg_pkg::*;
#(
  parameter int          CFG_AW      = 10,
  parameter int          REG_DW      = 24,
  parameter int          REQ_W       = 32,
  parameter logic [63:0] DEF_BASE    = 64'h0000_0000_B000_0000,
  parameter logic [63:0] IOAPIC_BASE = 64'h0000_0000_FEC0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_valid,
  output logic              cfg_wr_ready,
  input  logic [CFG_AW-1:0] cfg_wr_dw,
  input  logic [31:0]       cfg_wr_data,
  input  logic [3:0]        cfg_wr_be,
  input  logic [REQ_W-1:0]  req_addr,
  output logic              cfg_hit,
  output logic              win_en,
  output logic [PA_W-1:0]   win_base,
  output logic [PA_W-1:0]   win_len,
  output logic [PA_W-1:0]   hole_start,
  output logic [REQ_W-1:0]  hole_end,
  output logic              len_err
);
  logic [63:0] raw_next;
  logic        touch;
  win_dec_t    dec;

  assign cfg_wr_ready = 1'b1;

  mmcfg_cfg_port #(.CFG_AW(CFG_AW), .REG_DW(REG_DW), .RST_VAL(DEF_BASE)) u_port (
    .clk(clk), .rst_n(rst_n), .wr_fire(cfg_wr_valid && cfg_wr_ready),
    .wr_dw(cfg_wr_dw), .wr_data(cfg_wr_data), .wr_be(cfg_wr_be),
    .raw_next(raw_next), .touch(touch)
  );

  mmcfg_win_reg #(.RST_VAL(DEF_BASE)) u_reg (
    .clk(clk), .rst_n(rst_n), .touch(touch), .raw_next(raw_next),
    .dec(dec), .len_err(len_err)
  );

  mmcfg_hit_cmp #(.REQ_W(REQ_W), .DEF_BASE(DEF_BASE), .IOAPIC_BASE(IOAPIC_BASE)) u_cmp (
    .dec(dec), .req_addr(req_addr), .hit(cfg_hit),
    .hole_start(hole_start), .hole_end(hole_end)
  );

  assign win_en   = dec.en;
  assign win_base = dec.base;
  assign win_len  = dec.len;
endmodule

// File: rtl/mmcfg_window_chk.sv
module mmcfg_window_chk
  import mmcfg_pkg::*;
#(
  parameter int          REQ_W    = 32,
  parameter logic [63:0] DEF_BASE = 64'h0000_0000_B000_0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_valid,
  input logic [REQ_W-1:0] req_addr,
  input logic             cfg_hit,
  input logic             win_en,
  input logic [PA_W-1:0]  win_base,
  input logic [PA_W-1:0]  win_len,
  input logic [PA_W-1:0]  hole_start,
  input logic             len_err
);
  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> !cfg_hit); // R7
  AST_HIT_ABOVE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |-> (PA_W'(req_addr) >= win_base)); // R7
  AST_ERR_HOLDS_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> ($stable(win_en) && $stable(win_base) && $stable(win_len))); // R6
  AST_QUIET_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr_valid) |-> ($stable(win_en) && $stable(win_base) && $stable(win_len))); // R10
  AST_LEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(win_len) == 1); // R2
  AST_256_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    win_len[LG_MAX] |-> (win_base[LG_MAX-1:LG_MAX-2] == 2'b00)); // R3
  AST_BASE_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    win_base[LG_MAX-3:0] == '0); // R4
  AST_64_DROPS_B27: assert property (@(posedge clk) disable iff (!rst_n)
    win_len[LG_MAX-2] |-> !win_base[LG_MAX-1]); // R5
  AST_HOLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> (hole_start == DEF_BASE[PA_W-1:0])); // R8
endmodule

bind mmcfg_window_top mmcfg_window_chk #(.REQ_W(REQ_W), .DEF_BASE(DEF_BASE)) u_chk (.*);

// File: tb/mmcfg_window_top_bench.sv
module mmcfg_window_top_bench;
  import mmcfg_pkg::*;

  typedef struct {
    logic            en;
    logic [PA_W-1:0] base;
    logic [PA_W-1:0] len;
    logic [PA_W-1:0] hs;
    logic            err;
    string           tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_valid = 1'b0;
  logic cfg_wr_ready;
  logic [9:0]  cfg_wr_dw = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [3:0]  cfg_wr_be = '0;
  logic [31:0] req_addr = '0;
  logic cfg_hit, win_en, len_err;
  logic [PA_W-1:0] win_base, win_len, hole_start;
  logic [31:0] hole_end;

  int n_vec = 0;
  int n_bad = 0;
  exp_t exp_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  mmcfg_window_top u_mmcfg_window_top (
    .clk(clk), .rst_n(rst_n), .cfg_wr_valid(cfg_wr_valid), .cfg_wr_ready(cfg_wr_ready),
    .cfg_wr_dw(cfg_wr_dw), .cfg_wr_data(cfg_wr_data), .cfg_wr_be(cfg_wr_be),
    .req_addr(req_addr), .cfg_hit(cfg_hit), .win_en(win_en), .win_base(win_base),
    .win_len(win_len), .hole_start(hole_start), .hole_end(hole_end), .len_err(len_err)
  );

  localparam logic [PA_W-1:0] L256 = 36'h0_1000_0000;
  localparam logic [PA_W-1:0] L128 = 36'h0_0800_0000;
  localparam logic [PA_W-1:0] L64  = 36'h0_0400_0000;

  // monitor: pops expected decode and compares away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (win_en !== e.en || win_base !== e.base || win_len !== e.len ||
          hole_start !== e.hs || len_err !== e.err || hole_end !== 32'hFEBF_FFFF ||
          cfg_wr_ready !== 1'b1) begin
        n_bad++;
        $display("FAIL %s: got en=%0b base=%h len=%h hs=%h err=%0b end=%h rdy=%0b exp en=%0b base=%h len=%h hs=%h err=%0b end=febfffff rdy=1",
                 e.tag, win_en, win_base, win_len, hole_start, len_err, hole_end, cfg_wr_ready,
                 e.en, e.base, e.len, e.hs, e.err);
      end
    end
  end

  task automatic push(input logic en, input logic [PA_W-1:0] base, input logic [PA_W-1:0] len,
                      input logic [PA_W-1:0] hs, input logic err, input string tag);
    exp_t e;
    e.en = en; e.base = base; e.len = len; e.hs = hs; e.err = err; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wr(input logic [9:0] dw, input logic [31:0] d, input logic [3:0] be,
                    input logic en, input logic [PA_W-1:0] base, input logic [PA_W-1:0] len,
                    input logic [PA_W-1:0] hs, input logic err, input string tag);
    @(negedge clk);
    cfg_wr_valid = 1'b1; cfg_wr_dw = dw; cfg_wr_data = d; cfg_wr_be = be;
    @(posedge clk);
    #1 cfg_wr_valid = 1'b0;
    push(en, base, len, hs, err, tag);
  endtask

  task automatic idle(input logic en, input logic [PA_W-1:0] base, input logic [PA_W-1:0] len,
                      input logic [PA_W-1:0] hs, input string tag);
    @(negedge clk);
    @(posedge clk);
    #1 push(en, base, len, hs, 1'b0, tag);
  endtask

  task automatic probe(input logic [31:0] a, input logic exp_hit, input string tag);
    @(negedge clk);
    req_addr = a;
    #1;
    n_vec++;
    if (cfg_hit !== exp_hit) begin
      n_bad++;
      $display("FAIL %s: addr=%h hit got %0b exp %0b", tag, a, cfg_hit, exp_hit);
    end
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(1'b0, 36'h0_B000_0000, L256, 36'h0_B000_0000, "R1 reset decode");
    probe(32'hB000_0000, 1'b0, "R1 disabled after reset");

    // 256 MB window at 0xE000_0000
    wr(10'd24, 32'hE000_0001, 4'hF, 1'b1, 36'h0_E000_0000, L256, 36'h0_F000_0000, 1'b0, "R2 R3 R8 256MB");
    probe(32'hDFFF_FFFF, 1'b0, "R7 below base");
    probe(32'hE000_0000, 1'b1, "R7 at base");
    probe(32'hEFFF_FFFF, 1'b1, "R7 last byte");
    probe(32'hF000_0000, 1'b0, "R7 past end");

    // 128 MB keeps bits 27 and 26
    wr(10'd24, 32'hEC00_0003, 4'hF, 1'b1, 36'h0_EC00_0000, L128, 36'h0_F400_0000, 1'b0, "R4 128MB mask");
    probe(32'hF3FF_FFFF, 1'b1, "R7 128MB last");
    probe(32'hF400_0000, 1'b0, "R7 128MB past");
    probe(32'hEBFF_FFFF, 1'b0, "R7 128MB below");

    // 64 MB drops bit 27, keeps bit 26
    wr(10'd24, 32'hEC00_0005, 4'hF, 1'b1, 36'h0_E400_0000, L64, 36'h0_E800_0000, 1'b0, "R5 64MB mask");
    probe(32'hE7FF_FFFF, 1'b1, "R7 64MB last");
    probe(32'hEC00_0000, 1'b0, "R7 64MB unmasked addr");

    // 256 MB drops both
    wr(10'd24, 32'hEC00_0001, 4'hF, 1'b1, 36'h0_E000_0000, L256, 36'h0_F000_0000, 1'b0, "R3 256MB drops 27:26");

    // reserved length keeps decode
    wr(10'd24, 32'h8000_0007, 4'hF, 1'b1, 36'h0_E000_0000, L256, 36'h0_F000_0000, 1'b1, "R6 reserved write");
    idle(1'b1, 36'h0_E000_0000, L256, 36'h0_F000_0000, "R6 error one cycle");
    probe(32'hE000_0000, 1'b1, "R6 old window still hits");
    wr(10'd25, 32'h0000_0003, 4'h1, 1'b1, 36'h0_E000_0000, L256, 36'h0_F000_0000, 1'b1, "R6 upper write while reserved");
    wr(10'd24, 32'h8000_0001, 4'hF, 1'b1, 36'h3_8000_0000, L256, 36'h3_9000_0000, 1'b0, "R2 R3 high base bits");
    probe(32'h8000_0000, 1'b0, "R7 base above 4G");

    // byte lanes and ignored writes
    wr(10'd24, 32'hFFFF_FF00, 4'h1, 1'b0, 36'h3_8000_0000, L256, 36'h0_B000_0000, 1'b0, "R10 R8 single lane disable");
    wr(10'd25, 32'h0000_0000, 4'hF, 1'b0, 36'h0_8000_0000, L256, 36'h0_B000_0000, 1'b0, "R10 upper dword");
    probe(32'h8000_0000, 1'b0, "R7 enable clear");
    wr(10'd26, 32'hFFFF_FFFF, 4'hF, 1'b0, 36'h0_8000_0000, L256, 36'h0_B000_0000, 1'b0, "R10 foreign dword");
    wr(10'd24, 32'h0000_0001, 4'h0, 1'b0, 36'h0_8000_0000, L256, 36'h0_B000_0000, 1'b0, "R10 empty enables");
    probe(32'h8000_0000, 1'b0, "R10 still disabled");
    wr(10'd24, 32'h0000_0001, 4'h1, 1'b1, 36'h0_8000_0000, L256, 36'h0_9000_0000, 1'b0, "R11 R8 enable lane");
    probe(32'h8000_0000, 1'b1, "R7 enabled hit");
    probe(32'h9000_0000, 1'b0, "R9 R7 hole start not in window");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule